// File: doc/BRIEF.md
# Externally Clocked Serial Transmitter

This block sends parallel words out on one serial data line. The line is paced by a shift clock that a remote master drives, and the block generates no bit rate of its own. A write port loads a holding register, which passes words on to a shift register. Because of this double buffering, one word can wait while the previous word is still being clocked out. A buffer-empty flag and its enable produce an interrupt request that asks for the next word. A status output shows when nothing is being shifted.

The external clock first passes through an optional inverter and then through a synchronizer. The block treats the falling edge of this polarized clock as its active edge. On each active edge it moves to the next bit, so the master can sample the line on the rising edge. Words go out least significant bit first. A frame holds 8 or 9 bits, and in the 9-bit case the extra bit comes from a separate control input that is captured with the write. The data line can also be inverted.

The shifter is a two-state machine. In IDLE the line rests at the mark level. A load moves the machine to SHIFT (transition START). In SHIFT, the active edge that ends a word either takes the waiting word and stays in SHIFT (transition CHAIN), or returns to IDLE when no word waits (transition DONE). When the block leaves its enabled condition it is forced back to IDLE (transition ABORT).

Top module: `sync_slave_tx`

## Requirements
- R1: The shift register advances only on a falling edge of the polarized clock (`ext_sck` XOR `clk_inv`). At any other time `ser_out` stays constant while a word is being sent.
- R2: A write accepted while the shifter is idle goes straight into the shift register. In the next cycle `shift_idle` is 0, bit 0 is on the line and `tx_empty` stays 1.
- R3: A write accepted while a word is shifting is kept in the holding register, and `tx_empty` reads 0 until that word is handed off.
- R4: On the active edge that completes the current word, the held word enters the shift register. `tx_empty` returns to 1 in that same cycle and no earlier.
- R5: `irq` is 1 exactly when `tx_empty` and `tx_empty_ie` are both 1.
- R6: With `clk_inv`=1 the active edge becomes a rising edge of `ext_sck`. With `data_inv`=1, `ser_out` is the complement of the frame bit and of the idle level.
- R7: With `ninth_mode`=1 a frame has 9 bits, and bit 8 is the `ninth_bit` value sampled together with the write. With `ninth_mode`=0 a frame has 8 bits.
- R8: The block is enabled only when `port_en`=1, `tx_en`=1 and `rx_en`=0. Writes made at any other time are ignored.
- R9: Bits leave least significant bit first. The first bit appears on the line at load, and each active edge presents the next bit. When idle the line is at mark level 1 (before `data_inv`).
- R10: `shift_idle` is 1 exactly when no word is in the shift register.
- R11: Leaving the enabled condition empties both the shifter and the holding register in the next cycle, so `tx_empty`=1 and `shift_idle`=1.
- R12: A write made while the holding register is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Serial port enable |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable (blocks transmit when set) |
| ninth_mode | input | 1 | Selects 9-bit frames |
| ninth_bit | input | 1 | Value of bit 8, captured with the write |
| clk_inv | input | 1 | Inverts the external clock sense |
| data_inv | input | 1 | Inverts the serial output |
| tx_empty_ie | input | 1 | Interrupt enable for the buffer-empty flag |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Word to transmit |
| ext_sck | input | 1 | Shift clock from the external master |
| ser_out | output | 1 | Serial data line |
| tx_empty | output | 1 | Holding register can take a word |
| irq | output | 1 | Interrupt request |
| shift_idle | output | 1 | No word in the shift register |

## Verification
The assertions assume that `ext_sck` holds each level for at least four system clocks. This lets every polarized falling edge reach the shifter as a single one-cycle pulse. They also assume that control inputs change only between clock edges. The stimulus keeps each clock level for four cycles and sets every control and write input on the falling system-clock edge. It changes `clk_inv` only while the polarized level is high, so inverting the clock never produces a false edge.

// File: rtl/sst_pkg.sv
package sst_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } sst_state_e;
endpackage

// File: rtl/sst_clk_sync.sv
module sst_clk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_pol,
    output logic fall_o
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], sck_pol};
    end

    // one-cycle pulse when the synchronized level drops
    assign fall_o = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
    import sst_pkg::*;
#(
    parameter int FRAME_W = 9,
    parameter int LEN_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active_i,
    input  logic               edge_i,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] load_word,
    input  logic [LEN_W-1:0]   load_len,
    output logic               take_o,
    output logic               idle_o,
    output logic               bit_o
);
    sst_state_e state_q, state_d;
    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   left;
    logic               last;

    assign last = (left == LEN_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load_i) state_d = ST_SHIFT;
            ST_SHIFT: if (edge_i && last && !load_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (!active_i) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '1;
            left  <= '0;
        end else if (load_i) begin
            shreg <= load_word;
            left  <= load_len;
        end else if (state_q == ST_SHIFT && edge_i && !last) begin
            shreg <= shreg >> 1;
            left  <= left - LEN_W'(1);
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                take_o = 1'b1;
                idle_o = 1'b1;
                bit_o  = 1'b1;
            end
            ST_SHIFT: begin
                take_o = edge_i && last;
                idle_o = 1'b0;
                bit_o  = shreg[0];
            end
            default: begin
                take_o = 1'b0;
                idle_o = 1'b1;
                bit_o  = 1'b1;
            end
        endcase
    end

    // R1: contents hold still between active edges
    p_hold_between_edges_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && state_q == ST_SHIFT && !edge_i) |=> $stable(shreg));

    // R7: remaining bit count stays within one frame
    p_len_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (left >= LEN_W'(1) && left <= LEN_W'(FRAME_W)));
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              ninth_mode,
    input  logic              ninth_bit,
    input  logic              clk_inv,
    input  logic              data_inv,
    input  logic              tx_empty_ie,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_sck,
    output logic              ser_out,
    output logic              tx_empty,
    output logic              irq,
    output logic              shift_idle
);
    localparam int FRAME_W = DATA_W + 1;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    logic               active, sck_fall, take, accept, load;
    logic               hold_full, hold_long, ld_long, sh_bit;
    logic [FRAME_W-1:0] hold_word, wr_word, ld_word;
    logic [LEN_W-1:0]   ld_len;

    assign active  = port_en & tx_en & ~rx_en;
    assign wr_word = {ninth_mode & ninth_bit, wr_data};
    assign accept  = active & wr_valid & ~hold_full;
    assign load    = active & take & (hold_full | accept);
    assign ld_word = hold_full ? hold_word : wr_word;
    assign ld_long = hold_full ? hold_long : ninth_mode;
    assign ld_len  = ld_long ? LEN_W'(FRAME_W) : LEN_W'(DATA_W);

    sst_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_pol(ext_sck ^ clk_inv),
        .fall_o (sck_fall)
    );

    sst_shifter #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .edge_i   (sck_fall),
        .load_i   (load),
        .load_word(ld_word),
        .load_len (ld_len),
        .take_o   (take),
        .idle_o   (shift_idle),
        .bit_o    (sh_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_word <= '0;
            hold_long <= 1'b0;
        end else if (!active) begin
            hold_full <= 1'b0;
        end else if (hold_full && take) begin
            hold_full <= 1'b0;
        end else if (accept && !take) begin
            hold_full <= 1'b1;
            hold_word <= wr_word;
            hold_long <= ninth_mode;
        end
    end

    assign tx_empty = ~hold_full;
    assign irq      = tx_empty & tx_empty_ie;
    assign ser_out  = sh_bit ^ data_inv;

    // R11: dropping out of the enabled condition empties everything
    p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (tx_empty && shift_idle));

    // R3: a word queued behind a busy shifter clears the empty flag
    p_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !take) |=> !tx_empty);

    // R4: the held word stays until the shifter takes it
    p_hold_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && hold_full && !take) |=> !tx_empty);

    // R2: a write to an idle shifter starts shifting at once
    p_direct_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && shift_idle) |=> (!shift_idle && tx_empty));
endmodule

// File: tb/sync_slave_tx_tb.sv
module sync_slave_tx_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_en = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
    logic ninth_mode = 1'b0, ninth_bit = 1'b0;
    logic clk_inv = 1'b0, data_inv = 1'b0, tx_empty_ie = 1'b0;
    logic wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic sck_lvl = 1'b1;
    wire  ext_sck = sck_lvl ^ clk_inv;
    logic ser_out, tx_empty, irq, shift_idle;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit cmp_en = 0;

    always #10 clk = ~clk;

    sync_slave_tx u_dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en), .rx_en(rx_en),
        .ninth_mode(ninth_mode), .ninth_bit(ninth_bit), .clk_inv(clk_inv),
        .data_inv(data_inv), .tx_empty_ie(tx_empty_ie), .wr_valid(wr_valid),
        .wr_data(wr_data), .ext_sck(ext_sck), .ser_out(ser_out),
        .tx_empty(tx_empty), .irq(irq), .shift_idle(shift_idle)
    );

    // behavioural reference model
    bit m_s1, m_s2, m_s3, m_busy, m_hfull;
    int m_left, m_hlen;
    int m_sh, m_hw;

    always @(posedge clk) begin
        bit act, edg, take, acc;
        int wword, wlen;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_busy = 0; m_hfull = 0;
            m_left = 0; m_hlen = 0; m_sh = 0; m_hw = 0;
        end else begin
            act = port_en && tx_en && !rx_en;
            edg = m_s3 && !m_s2;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_sck ^ clk_inv;
            wword = int'(wr_data) + ((ninth_mode && ninth_bit) ? 256 : 0);
            wlen  = ninth_mode ? 9 : 8;
            if (!act) begin
                m_busy = 0; m_hfull = 0;
            end else begin
                take = !m_busy || (edg && m_left == 1);
                acc  = wr_valid && !m_hfull;
                if (m_busy && edg && m_left > 1) begin
                    m_sh = m_sh / 2; m_left = m_left - 1;
                end
                if (take) begin
                    if (m_hfull) begin
                        m_sh = m_hw; m_left = m_hlen; m_hfull = 0; m_busy = 1;
                    end else if (acc) begin
                        m_sh = wword; m_left = wlen; acc = 0; m_busy = 1;
                    end else begin
                        m_busy = 0;
                    end
                end
                if (acc) begin
                    m_hfull = 1; m_hw = wword; m_hlen = wlen;
                end
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (cmp_en && !done) begin
            check("R1/R9 ser_out vs model", int'(ser_out),
                  int'(data_inv ^ (m_busy ? m_sh[0] : 1'b1)));
            check("R4 tx_empty vs model", int'(tx_empty), int'(!m_hfull));
            check("R5 irq vs model", int'(irq), int'(!m_hfull && tx_empty_ie));
            check("R10 shift_idle vs model", int'(shift_idle), int'(!m_busy));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d, logic nb);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d; ninth_bit = nb;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        sck_lvl = 1'b0;
        cyc(4);
        sck_lvl = 1'b1;
        cyc(4);
    endtask

    task automatic rx_frame(int n, output int word);
        word = 0;
        for (int k = 0; k < n; k++) begin
            #2;
            if (ser_out ^ data_inv) word = word | (1 << k);
            pulse();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int got, got2;
        cyc(3);
        rst_n = 1'b1;
        port_en = 1'b1; tx_en = 1'b1;
        cmp_en = 1;
        cyc(2);
        #2;
        check("reset tx_empty R4", int'(tx_empty), 1);
        check("reset shift_idle R10", int'(shift_idle), 1);
        check("reset idle mark R9", int'(ser_out), 1);
        check("reset irq R5", int'(irq), 0);

        // R2, R9: direct load, LSB first
        wr(8'hA5, 1'b0);
        #2;
        check("R2 busy after write", int'(shift_idle), 0);
        check("R2 flag stays set", int'(tx_empty), 1);
        // R1: no edges, line holds
        cyc(20);
        #2;
        check("R1 line held without edges", int'(ser_out), 1);
        rx_frame(8, got);
        check("R9 lsb-first 8-bit word", got, 8'hA5);
        cyc(2);
        #2;
        check("R10 idle after frame", int'(shift_idle), 1);

        // R3, R4, R5, R12: double buffering
        tx_empty_ie = 1'b1;
        wr(8'h3C, 1'b0);
        wr(8'hC1, 1'b0);
        #2;
        check("R3 flag cleared with pending word", int'(tx_empty), 0);
        check("R5 irq low while pending", int'(irq), 0);
        wr(8'hFF, 1'b0);
        rx_frame(8, got);
        #2;
        check("R4 flag set on hand-off", int'(tx_empty), 1);
        check("R5 irq with flag", int'(irq), 1);
        check("R4 second word loaded", int'(shift_idle), 0);
        check("R9 first of pair", got, 8'h3C);
        rx_frame(8, got2);
        check("R12 dropped write not sent", got2, 8'hC1);
        cyc(2);
        #2;
        check("R12 idle after two frames", int'(shift_idle), 1);

        // R7: nine-bit frame
        ninth_mode = 1'b1;
        wr(8'h5A, 1'b1);
        rx_frame(9, got);
        check("R7 nine-bit frame", got, 9'h15A);
        ninth_mode = 1'b0;

        // R6: inverted clock and data
        cyc(2);
        #2;
        check("R6 inverted idle level", int'(ser_out), 1);
        clk_inv = 1'b1; data_inv = 1'b1;
        cyc(6);
        #2;
        check("R6 inverted idle line", int'(ser_out), 0);
        wr(8'h96, 1'b0);
        rx_frame(8, got);
        check("R6 word with inversions", got, 8'h96);
        clk_inv = 1'b0; data_inv = 1'b0;
        cyc(6);

        // R8: receive enable blocks writes
        rx_en = 1'b1;
        wr(8'h77, 1'b0);
        #2;
        check("R8 write ignored tx_empty", int'(tx_empty), 1);
        check("R8 write ignored shifter", int'(shift_idle), 1);
        rx_en = 1'b0;
        cyc(2);

        // R11: flush on tx_en clear
        wr(8'h11, 1'b0);
        wr(8'h22, 1'b0);
        pulse();
        @(negedge clk);
        tx_en = 1'b0;
        cyc(1);
        #2;
        check("R11 hold flushed", int'(tx_empty), 1);
        check("R11 shifter flushed", int'(shift_idle), 1);
        tx_en = 1'b1;
        cyc(2);
        wr(8'h4E, 1'b0);
        rx_frame(8, got);
        check("R11 clean restart", got, 8'h4E);
        cyc(4);
        finish_run();
    end
endmodule